// File: doc/BRIEF.md
# Shared AXI Write-Address Tagger and Response Router

Three requesters inside a data cache share one AXI write-address channel: a write buffer, a flush controller and an uncached controller. This block picks one pending request at a time using round-robin arbitration. It stamps the forwarded AW beat with an ID that names the source, and for the write buffer and the flush controller it also names the entry. The winning address goes out on the shared channel.

On the write-response channel the block decodes each returned ID and routes the response to the requester and entry that issued the write. The all-ones ID is reserved for uncached writes. The number of flush entries is therefore capped, so that no flush ID can equal that value. The cap is checked at elaboration and does not require a power-of-two entry count.

Top module: `axi_wid_router`

## Requirements
- R1: A write-buffer request with entry index k leaves with ID {1'b0, k[2:0]} (4-bit ID).
- R2: A flush request with entry index k leaves with ID {1'b1, k[2:0]}.
- R3: An uncached request leaves with ID 4'hF.
- R4: After reset no AW beat is offered until a request is pending. With all three sources requesting continuously, grants rotate write buffer, flush, uncached, and the write buffer goes first after reset.
- R5: While an offered AW beat is not accepted, its address and ID stay unchanged until the slave accepts it.
- R6: At most one source sees its AW ready in a cycle. That source is the one whose beat the slave accepts in that cycle.
- R7: A response whose ID has MSB 0 goes to the write buffer, with entry index equal to ID[2:0].
- R8: A response with ID 4'hF goes to the uncached controller.
- R9: A response with MSB 1 and any other ID goes to the flush controller, with entry index equal to ID[2:0].
- R10: At most one response valid output is high. The ready returned to the slave equals the ready of the requester that the current response ID selects.
- R11: The configuration is rejected at elaboration if the flush entry count exceeds 2^(ID_W-1)-1. The highest legal flush entry (index 6 by default) therefore never produces the all-ones ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_aw_valid_i | input | 1 | Write-buffer AW request |
| wb_aw_ready_o | output | 1 | Write-buffer AW accepted |
| wb_aw_addr_i | input | ADDR_W | Write-buffer address |
| wb_aw_idx_i | input | ID_W-1 | Write-buffer entry index |
| fl_aw_valid_i | input | 1 | Flush AW request |
| fl_aw_ready_o | output | 1 | Flush AW accepted |
| fl_aw_addr_i | input | ADDR_W | Flush address |
| fl_aw_idx_i | input | ID_W-1 | Flush entry index |
| uc_aw_valid_i | input | 1 | Uncached AW request |
| uc_aw_ready_o | output | 1 | Uncached AW accepted |
| uc_aw_addr_i | input | ADDR_W | Uncached address |
| m_aw_valid_o | output | 1 | Shared AW valid |
| m_aw_ready_i | input | 1 | Shared AW ready |
| m_aw_addr_o | output | ADDR_W | Shared AW address |
| m_aw_id_o | output | ID_W | Shared AW ID |
| m_b_valid_i | input | 1 | Shared B valid |
| m_b_ready_o | output | 1 | Shared B ready |
| m_b_id_i | input | ID_W | Shared B ID |
| m_b_resp_i | input | 2 | Shared B response code |
| wb_b_valid_o | output | 1 | Response to write buffer |
| wb_b_ready_i | input | 1 | Write buffer ready for response |
| fl_b_valid_o | output | 1 | Response to flush controller |
| fl_b_ready_i | input | 1 | Flush controller ready for response |
| uc_b_valid_o | output | 1 | Response to uncached controller |
| uc_b_ready_i | input | 1 | Uncached controller ready for response |
| b_idx_o | output | ID_W-1 | Entry index of the routed response |
| b_resp_o | output | 2 | Response code of the routed response |

## Verification
The hold property assumes that each requester behaves as an AXI master. Once it raises its AW valid, it keeps the valid, address and index unchanged until it sees its ready. The entry indices are assumed to stay within each source's configured entry count. The stimulus meets both conditions: every agent drives its request from the head of a queue and removes that entry only after the handshake. Flush indices never exceed the top legal entry. Stalls come from a gated slave-side AW ready and from requester B readies that toggle on different periods.

// File: rtl/wid_router_pkg.sv
`timescale 1ns/1ps
package wid_router_pkg;
  localparam int unsigned NUM_SRC = 3;
  typedef enum logic [1:0] {
    SRC_WB = 2'd0,
    SRC_FL = 2'd1,
    SRC_UC = 2'd2
  } src_e;
endpackage

// File: rtl/wid_rr_arb.sv
`timescale 1ns/1ps
module wid_rr_arb #(
  parameter int unsigned N  = 3,
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          ack_i,
  output logic [N-1:0]  gnt_o,
  output logic [SW-1:0] gnt_idx_o,
  output logic          gnt_vld_o
);
  logic          lock_q;
  logic [SW-1:0] lock_idx_q, last_q;
  logic [SW-1:0] pick_idx, cand;
  logic          pick_vld;

  // nearest requester after the last winner wins: scan far to near
  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    cand     = '0;
    for (int k = N; k >= 1; k--) begin
      cand = SW'((int'(last_q) + k) % N);
      if (req_i[cand]) begin
        pick_vld = 1'b1;
        pick_idx = cand;
      end
    end
  end

  assign gnt_idx_o = lock_q ? lock_idx_q : pick_idx;
  assign gnt_vld_o = lock_q ? req_i[lock_idx_q] : pick_vld;
  assign gnt_o     = gnt_vld_o ? (N'(1) << gnt_idx_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
      last_q     <= SW'(N - 1);
    end else if (gnt_vld_o && ack_i) begin
      lock_q <= 1'b0;
      last_q <= gnt_idx_o;
    end else if (gnt_vld_o) begin
      lock_q     <= 1'b1;
      lock_idx_q <= gnt_idx_o;
    end
  end
endmodule

// File: rtl/wid_id_encode.sv
`timescale 1ns/1ps
module wid_id_encode
  import wid_router_pkg::*;
#(
  parameter int unsigned ID_W   = 4,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned IDX_W = ID_W - 1
) (
  input  logic [1:0]        sel_i,
  input  logic [ADDR_W-1:0] wb_addr_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  logic [ADDR_W-1:0] fl_addr_i,
  input  logic [IDX_W-1:0]  fl_idx_i,
  input  logic [ADDR_W-1:0] uc_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ID_W-1:0]   id_o
);
  always_comb begin
    unique case (src_e'(sel_i))
      SRC_WB: begin
        addr_o = wb_addr_i;
        id_o   = {1'b0, wb_idx_i};
      end
      SRC_FL: begin
        addr_o = fl_addr_i;
        id_o   = {1'b1, fl_idx_i};
      end
      default: begin
        addr_o = uc_addr_i;
        id_o   = '1;
      end
    endcase
  end
endmodule

// File: rtl/wid_b_decode.sv
`timescale 1ns/1ps
module wid_b_decode #(
  parameter int unsigned ID_W = 4,
  localparam int unsigned IDX_W = ID_W - 1
) (
  input  logic             valid_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic             wb_rdy_i,
  input  logic             fl_rdy_i,
  input  logic             uc_rdy_i,
  output logic             wb_vld_o,
  output logic             fl_vld_o,
  output logic             uc_vld_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             ready_o
);
  logic is_wb, is_uc, is_fl;

  assign is_wb = ~id_i[ID_W-1];
  assign is_uc = &id_i;
  assign is_fl = ~is_wb & ~is_uc;

  assign wb_vld_o = valid_i & is_wb;
  assign fl_vld_o = valid_i & is_fl;
  assign uc_vld_o = valid_i & is_uc;
  assign idx_o    = id_i[IDX_W-1:0];
  assign ready_o  = is_wb ? wb_rdy_i : (is_uc ? uc_rdy_i : fl_rdy_i);
endmodule

// File: rtl/axi_wid_router.sv
`timescale 1ns/1ps
module axi_wid_router
  import wid_router_pkg::*;
#(
  parameter int unsigned ID_W       = 4,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WB_ENTRIES = 8,
  parameter int unsigned FL_ENTRIES = 7,
  localparam int unsigned IDX_W     = ID_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_aw_valid_i,
  output logic              wb_aw_ready_o,
  input  logic [ADDR_W-1:0] wb_aw_addr_i,
  input  logic [IDX_W-1:0]  wb_aw_idx_i,
  input  logic              fl_aw_valid_i,
  output logic              fl_aw_ready_o,
  input  logic [ADDR_W-1:0] fl_aw_addr_i,
  input  logic [IDX_W-1:0]  fl_aw_idx_i,
  input  logic              uc_aw_valid_i,
  output logic              uc_aw_ready_o,
  input  logic [ADDR_W-1:0] uc_aw_addr_i,
  output logic              m_aw_valid_o,
  input  logic              m_aw_ready_i,
  output logic [ADDR_W-1:0] m_aw_addr_o,
  output logic [ID_W-1:0]   m_aw_id_o,
  input  logic              m_b_valid_i,
  output logic              m_b_ready_o,
  input  logic [ID_W-1:0]   m_b_id_i,
  input  logic [1:0]        m_b_resp_i,
  output logic              wb_b_valid_o,
  input  logic              wb_b_ready_i,
  output logic              fl_b_valid_o,
  input  logic              fl_b_ready_i,
  output logic              uc_b_valid_o,
  input  logic              uc_b_ready_i,
  output logic [IDX_W-1:0]  b_idx_o,
  output logic [1:0]        b_resp_o
);
  // flush IDs must keep a zero bit so they never alias the uncached ID
  if (FL_ENTRIES > (2 ** IDX_W) - 1) begin : g_bad_fl_cfg
    $error("flush entry count too large for ID width");
  end
  if (WB_ENTRIES > 2 ** IDX_W) begin : g_bad_wb_cfg
    $error("write buffer entry count too large for ID width");
  end

  logic [NUM_SRC-1:0] req, gnt;
  logic [1:0]         gnt_idx;
  logic               gnt_vld;

  assign req = {uc_aw_valid_i, fl_aw_valid_i, wb_aw_valid_i};

  wid_rr_arb #(.N(NUM_SRC)) i_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .ack_i     (m_aw_ready_i),
    .gnt_o     (gnt),
    .gnt_idx_o (gnt_idx),
    .gnt_vld_o (gnt_vld)
  );

  wid_id_encode #(.ID_W(ID_W), .ADDR_W(ADDR_W)) i_enc (
    .sel_i     (gnt_idx),
    .wb_addr_i (wb_aw_addr_i),
    .wb_idx_i  (wb_aw_idx_i),
    .fl_addr_i (fl_aw_addr_i),
    .fl_idx_i  (fl_aw_idx_i),
    .uc_addr_i (uc_aw_addr_i),
    .addr_o    (m_aw_addr_o),
    .id_o      (m_aw_id_o)
  );

  assign m_aw_valid_o  = gnt_vld;
  assign wb_aw_ready_o = gnt[SRC_WB] & m_aw_ready_i;
  assign fl_aw_ready_o = gnt[SRC_FL] & m_aw_ready_i;
  assign uc_aw_ready_o = gnt[SRC_UC] & m_aw_ready_i;

  wid_b_decode #(.ID_W(ID_W)) i_bdec (
    .valid_i  (m_b_valid_i),
    .id_i     (m_b_id_i),
    .wb_rdy_i (wb_b_ready_i),
    .fl_rdy_i (fl_b_ready_i),
    .uc_rdy_i (uc_b_ready_i),
    .wb_vld_o (wb_b_valid_o),
    .fl_vld_o (fl_b_valid_o),
    .uc_vld_o (uc_b_valid_o),
    .idx_o    (b_idx_o),
    .ready_o  (m_b_ready_o)
  );

  assign b_resp_o = m_b_resp_i;
endmodule

// File: rtl/axi_wid_router_chk.sv
`timescale 1ns/1ps
module axi_wid_router_chk #(
  parameter int unsigned ID_W   = 4,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned IDX_W = ID_W - 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wb_aw_ready_o,
  input logic [IDX_W-1:0]  wb_aw_idx_i,
  input logic              fl_aw_ready_o,
  input logic [IDX_W-1:0]  fl_aw_idx_i,
  input logic              uc_aw_ready_o,
  input logic              m_aw_valid_o,
  input logic              m_aw_ready_i,
  input logic [ADDR_W-1:0] m_aw_addr_o,
  input logic [ID_W-1:0]   m_aw_id_o,
  input logic              m_b_valid_i,
  input logic [ID_W-1:0]   m_b_id_i,
  input logic              m_b_ready_o,
  input logic              wb_b_valid_o,
  input logic              wb_b_ready_i,
  input logic              fl_b_valid_o,
  input logic              fl_b_ready_i,
  input logic              uc_b_valid_o,
  input logic              uc_b_ready_i
);
  p_wb_id_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_aw_ready_o |-> m_aw_id_o == {1'b0, wb_aw_idx_i});
  p_fl_id_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_aw_ready_o |-> m_aw_id_o == {1'b1, fl_aw_idx_i});
  p_uc_id_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uc_aw_ready_o |-> &m_aw_id_o);
  p_aw_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_aw_valid_o && !m_aw_ready_i) |=>
      (m_aw_valid_o && $stable(m_aw_id_o) && $stable(m_aw_addr_o)));
  p_one_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wb_aw_ready_o, fl_aw_ready_o, uc_aw_ready_o}));
  p_ready_hs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_aw_ready_o || fl_aw_ready_o || uc_aw_ready_o) |-> (m_aw_valid_o && m_aw_ready_i));
  p_wb_route_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_b_valid_i && !m_b_id_i[ID_W-1]) |-> wb_b_valid_o);
  p_uc_route_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_b_valid_i && &m_b_id_i) |-> uc_b_valid_o);
  p_fl_route_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_b_valid_i && m_b_id_i[ID_W-1] && !(&m_b_id_i)) |-> fl_b_valid_o);
  p_b_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wb_b_valid_o, fl_b_valid_o, uc_b_valid_o}));
  p_b_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_b_valid_i |-> (m_b_ready_o == ((wb_b_valid_o && wb_b_ready_i) ||
                                     (fl_b_valid_o && fl_b_ready_i) ||
                                     (uc_b_valid_o && uc_b_ready_i))));
  p_fl_not_uc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_aw_ready_o |-> !(&m_aw_id_o));
endmodule

bind axi_wid_router axi_wid_router_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wb_aw_ready_o (wb_aw_ready_o),
  .wb_aw_idx_i   (wb_aw_idx_i),
  .fl_aw_ready_o (fl_aw_ready_o),
  .fl_aw_idx_i   (fl_aw_idx_i),
  .uc_aw_ready_o (uc_aw_ready_o),
  .m_aw_valid_o  (m_aw_valid_o),
  .m_aw_ready_i  (m_aw_ready_i),
  .m_aw_addr_o   (m_aw_addr_o),
  .m_aw_id_o     (m_aw_id_o),
  .m_b_valid_i   (m_b_valid_i),
  .m_b_id_i      (m_b_id_i),
  .m_b_ready_o   (m_b_ready_o),
  .wb_b_valid_o  (wb_b_valid_o),
  .wb_b_ready_i  (wb_b_ready_i),
  .fl_b_valid_o  (fl_b_valid_o),
  .fl_b_ready_i  (fl_b_ready_i),
  .uc_b_valid_o  (uc_b_valid_o),
  .uc_b_ready_i  (uc_b_ready_i)
);

// File: tb/test_axi_wid_router.sv
`timescale 1ns/1ps
module test_axi_wid_router;
  localparam int ID_W = 4, IDX_W = 3, ADDR_W = 32;

  typedef struct packed { logic [ADDR_W-1:0] addr; logic [IDX_W-1:0] idx; } req_t;
  typedef struct packed { logic [1:0] src; logic [ID_W-1:0] id; logic [ADDR_W-1:0] addr; } aw_exp_t;
  typedef struct packed { logic [ID_W-1:0] id; logic [1:0] resp; } b_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wb_aw_valid_i = 1'b0, fl_aw_valid_i = 1'b0, uc_aw_valid_i = 1'b0;
  logic [ADDR_W-1:0] wb_aw_addr_i = '0, fl_aw_addr_i = '0, uc_aw_addr_i = '0;
  logic [IDX_W-1:0] wb_aw_idx_i = '0, fl_aw_idx_i = '0;
  logic m_aw_ready_i = 1'b0, m_b_valid_i = 1'b0;
  logic [ID_W-1:0] m_b_id_i = '0;
  logic [1:0] m_b_resp_i = '0;
  logic wb_b_ready_i = 1'b0, fl_b_ready_i = 1'b0, uc_b_ready_i = 1'b0;
  logic wb_aw_ready_o, fl_aw_ready_o, uc_aw_ready_o, m_aw_valid_o, m_b_ready_o;
  logic [ADDR_W-1:0] m_aw_addr_o;
  logic [ID_W-1:0] m_aw_id_o;
  logic wb_b_valid_o, fl_b_valid_o, uc_b_valid_o;
  logic [IDX_W-1:0] b_idx_o;
  logic [1:0] b_resp_o;

  always #2.5 clk = ~clk;

  axi_wid_router i_axi_wid_router (
    .clk_i(clk), .rst_ni(rst_ni),
    .wb_aw_valid_i(wb_aw_valid_i), .wb_aw_ready_o(wb_aw_ready_o),
    .wb_aw_addr_i(wb_aw_addr_i), .wb_aw_idx_i(wb_aw_idx_i),
    .fl_aw_valid_i(fl_aw_valid_i), .fl_aw_ready_o(fl_aw_ready_o),
    .fl_aw_addr_i(fl_aw_addr_i), .fl_aw_idx_i(fl_aw_idx_i),
    .uc_aw_valid_i(uc_aw_valid_i), .uc_aw_ready_o(uc_aw_ready_o),
    .uc_aw_addr_i(uc_aw_addr_i),
    .m_aw_valid_o(m_aw_valid_o), .m_aw_ready_i(m_aw_ready_i),
    .m_aw_addr_o(m_aw_addr_o), .m_aw_id_o(m_aw_id_o),
    .m_b_valid_i(m_b_valid_i), .m_b_ready_o(m_b_ready_o),
    .m_b_id_i(m_b_id_i), .m_b_resp_i(m_b_resp_i),
    .wb_b_valid_o(wb_b_valid_o), .wb_b_ready_i(wb_b_ready_i),
    .fl_b_valid_o(fl_b_valid_o), .fl_b_ready_i(fl_b_ready_i),
    .uc_b_valid_o(uc_b_valid_o), .uc_b_ready_i(uc_b_ready_i),
    .b_idx_o(b_idx_o), .b_resp_o(b_resp_o)
  );

  req_t    wb_q[$], fl_q[$], uc_q[$];
  aw_exp_t aw_exp[$];
  b_t      b_q[$];
  int total = 0, bad = 0, cyc = 0;
  bit stall_mode = 1'b0;
  bit hs_wb, hs_fl, hs_uc, hs_b, prev_stall;
  logic [ID_W-1:0]   prev_id;
  logic [ADDR_W-1:0] prev_addr;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [ID_W-1:0] exp_id(input int src, input logic [IDX_W-1:0] idx);
    if (src == 0) return {1'b0, idx};
    if (src == 1) return {1'b1, idx};
    return '1;
  endfunction

  task automatic push_aw(input int src, input logic [ADDR_W-1:0] addr, input logic [IDX_W-1:0] idx);
    req_t r;
    aw_exp_t e;
    r.addr = addr; r.idx = idx;
    e.src = 2'(src); e.id = exp_id(src, idx); e.addr = addr;
    if (src == 0) wb_q.push_back(r);
    else if (src == 1) fl_q.push_back(r);
    else uc_q.push_back(r);
    aw_exp.push_back(e);
  endtask

  task automatic drain(input int limit);
    int n = 0;
    while ((aw_exp.size() != 0 || b_q.size() != 0) && n < limit) begin
      @(posedge clk);
      n++;
    end
    if (n >= limit) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=%0d expected=0 items left", aw_exp.size() + b_q.size());
    end
  endtask

  // agents and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      hs_wb = wb_aw_valid_i && wb_aw_ready_o;
      hs_fl = fl_aw_valid_i && fl_aw_ready_o;
      hs_uc = uc_aw_valid_i && uc_aw_ready_o;
      hs_b  = m_b_valid_i && m_b_ready_o;
      if (rst_ni) begin
        if (prev_stall) begin
          check(m_aw_valid_o && m_aw_id_o == prev_id, "R5", "held id", 64'(m_aw_id_o), 64'(prev_id));
          check(m_aw_addr_o == prev_addr, "R5", "held addr", 64'(m_aw_addr_o), 64'(prev_addr));
        end
        prev_stall = m_aw_valid_o && !m_aw_ready_i;
        prev_id = m_aw_id_o;
        prev_addr = m_aw_addr_o;
        if (m_aw_valid_o && m_aw_ready_i) begin
          if (aw_exp.size() == 0) check(1'b0, "R4", "unexpected aw", 64'(m_aw_addr_o), 64'(0));
          else begin
            aw_exp_t e;
            string tag;
            e = aw_exp.pop_front();
            tag = (e.src == 0) ? "R1" : (e.src == 1) ? "R2" : "R3";
            check(m_aw_id_o == e.id, tag, "aw id", 64'(m_aw_id_o), 64'(e.id));
            check(m_aw_addr_o == e.addr, "R4", "grant order/addr", 64'(m_aw_addr_o), 64'(e.addr));
            check({uc_aw_ready_o, fl_aw_ready_o, wb_aw_ready_o} == (3'b001 << e.src), "R6", "aw ready vector",
                  64'({uc_aw_ready_o, fl_aw_ready_o, wb_aw_ready_o}), 64'(3'b001 << e.src));
            if (e.src == 1) check(m_aw_id_o != 4'hF, "R11", "flush id not all ones", 64'(m_aw_id_o), 64'(e.id));
          end
        end
        if (m_b_valid_i && b_q.size() != 0) begin
          b_t h;
          int tgt;
          logic trdy;
          string tag;
          h = b_q[0];
          tgt = !h.id[3] ? 0 : (&h.id) ? 2 : 1;
          trdy = (tgt == 0) ? wb_b_ready_i : (tgt == 1) ? fl_b_ready_i : uc_b_ready_i;
          tag = (tgt == 0) ? "R7" : (tgt == 1) ? "R9" : "R8";
          check({uc_b_valid_o, fl_b_valid_o, wb_b_valid_o} == (3'b001 << tgt), tag, "b valid vector",
                64'({uc_b_valid_o, fl_b_valid_o, wb_b_valid_o}), 64'(3'b001 << tgt));
          check(m_b_ready_o == trdy, "R10", "b ready follows target", 64'(m_b_ready_o), 64'(trdy));
          if (m_b_ready_o) begin
            if (tgt != 2) check(b_idx_o == h.id[2:0], tag, "b index", 64'(b_idx_o), 64'(h.id[2:0]));
            check(b_resp_o == h.resp, tag, "b resp", 64'(b_resp_o), 64'(h.resp));
          end
        end
      end
      @(posedge clk);
      #1;
      cyc++;
      if (hs_wb) wb_q.delete(0);
      if (hs_fl) fl_q.delete(0);
      if (hs_uc) uc_q.delete(0);
      if (hs_b)  b_q.delete(0);
      wb_aw_valid_i = wb_q.size() != 0;
      if (wb_aw_valid_i) begin wb_aw_addr_i = wb_q[0].addr; wb_aw_idx_i = wb_q[0].idx; end
      fl_aw_valid_i = fl_q.size() != 0;
      if (fl_aw_valid_i) begin fl_aw_addr_i = fl_q[0].addr; fl_aw_idx_i = fl_q[0].idx; end
      uc_aw_valid_i = uc_q.size() != 0;
      if (uc_aw_valid_i) uc_aw_addr_i = uc_q[0].addr;
      m_aw_ready_i = stall_mode ? (cyc % 3 == 0) : 1'b1;
      m_b_valid_i = b_q.size() != 0;
      if (m_b_valid_i) begin m_b_id_i = b_q[0].id; m_b_resp_i = b_q[0].resp; end
      wb_b_ready_i = (cyc % 2 == 0);
      fl_b_ready_i = (cyc % 3 != 1);
      uc_b_ready_i = (cyc % 4 != 3);
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // R4: nothing offered after reset; R6/R10 idle outputs
    check(m_aw_valid_o == 1'b0, "R4", "aw valid after reset", 64'(m_aw_valid_o), 64'(0));
    check({uc_aw_ready_o, fl_aw_ready_o, wb_aw_ready_o} == 3'b000, "R6", "aw readies after reset",
          64'({uc_aw_ready_o, fl_aw_ready_o, wb_aw_ready_o}), 64'(0));
    check({uc_b_valid_o, fl_b_valid_o, wb_b_valid_o} == 3'b000, "R10", "b valids idle",
          64'({uc_b_valid_o, fl_b_valid_o, wb_b_valid_o}), 64'(0));
    @(posedge clk); #2;
    // R4: all three pending, rotation wb, fl, uc
    for (int i = 0; i < 3; i++) begin
      push_aw(0, 32'h1000 + 32'(i * 4), 3'(i + 1));
      push_aw(1, 32'h2000 + 32'(i * 4), 3'(i + 4));
      push_aw(2, 32'h3000 + 32'(i * 4), 3'(0));
    end
    drain(2000);
    // R5: same rotation with a stalling slave
    stall_mode = 1'b1;
    @(posedge clk); #2;
    for (int i = 0; i < 3; i++) begin
      push_aw(0, 32'h4000 + 32'(i * 4), 3'(7 - i));
      push_aw(1, 32'h5000 + 32'(i * 4), 3'(6 - i));
      push_aw(2, 32'h6000 + 32'(i * 4), 3'(0));
    end
    drain(2000);
    // R1: every write buffer index, under stall
    @(posedge clk); #2;
    for (int i = 0; i < 8; i++) push_aw(0, 32'h7000 + 32'(i * 16), 3'(i));
    drain(2000);
    stall_mode = 1'b0;
    // R2, R11: every legal flush index including the top one
    @(posedge clk); #2;
    for (int i = 0; i < 7; i++) push_aw(1, 32'h8000 + 32'(i * 16), 3'(i));
    drain(2000);
    // R3
    @(posedge clk); #2;
    push_aw(2, 32'h9000, 3'(0));
    push_aw(2, 32'h9004, 3'(0));
    drain(2000);
    // R7, R8, R9, R10: every response ID
    @(posedge clk); #2;
    for (int i = 0; i < 16; i++) begin
      b_t b;
      b.id = 4'(i);
      b.resp = 2'(i ^ (i >> 2));
      b_q.push_back(b);
    end
    drain(4000);
    repeat (3) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule